// File: doc/BRIEF.md
# Five-Master Shared Bus Arbiter

This block decides which of five bus masters owns a shared system bus. The masters are, by index, a processor (0), a DMA engine (1), a bridge port (2), a USB controller (3) and an LCD controller (4). Each master raises a request line. The arbiter answers with a one-hot grant and keeps it until the owner reports that its transfer is finished.

A 32-bit configuration word sets the policy. It can be written and read through a simple port. In rotating mode the masters take turns in index order. In priority mode each master carries a level from 1 to 5, and the highest requesting level wins. Masters that share the winning level take turns, and each level keeps its own turn pointer.

The block is placed beside the bus fabric. The fabric drives `xfer_done` when the current owner's transfer ends.

Top module: `bus_arb5`

## Requirements
- R1: After reset `grant` is all zero, `cfg_rdata` reads 0x00000145, and the arbiter is in rotating mode with every turn pointer on master 0.
- R2: When `cfg_we` is high at a clock edge, all 32 bits of `cfg_wdata` are stored, and `cfg_rdata` shows them from that edge onward.
- R3: At most one `grant` bit is high at any time, and a newly issued grant always goes to a master whose request was high at the deciding edge.
- R4: When no request is high at an arbitration point, `grant` is all zero after that edge.
- R5: While a grant is held and `xfer_done` is low, `grant` does not change, whatever happens on the requests and the configuration port.
- R6: An arbitration point is any clock edge at which `grant` is zero or `xfer_done` is high. The new grant is visible right after that edge.
- R7: With configuration bit 0 equal to 1 (rotating mode), the search starts at the master after the last one granted in this mode, wrapping from 4 to 0. A master that keeps requesting is granted within 5 arbitration points that issue a grant.
- R8: With configuration bit 0 equal to 0 (priority mode), master i takes its level from bits [3i+3:3i+1]. The grant goes to a requester with the largest level present.
- R9: A level field of 0, 6 or 7 counts as level 1.
- R10: In priority mode, requesters tied at the top level are served in rotation. The rotation uses a pointer kept for that level alone, which moves to the master after the one granted.
- R11: A configuration write is first used at the first arbitration point after the edge that stores it. It never affects a grant that is being held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 5 | Request per master, bit i belongs to master i |
| xfer_done | input | 1 | Current owner's transfer ends this cycle |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Stored configuration word |
| grant | output | 5 | One-hot grant, bit i belongs to master i |

## Verification
Every decision is taken at one edge and shows on `grant` right after that edge, so each result is due one cycle after its inputs are applied. A configuration write shows on `cfg_rdata` in the same cycle as a grant taken at that edge. That grant still follows the configuration stored before the write. The bench therefore applies inputs on the falling edge and samples on the next falling edge. Its reference model takes each decision with the configuration it held before the cycle's write, and applies the write only after that decision.

// File: rtl/bus_arb5_pkg.sv
// Package: shared constants, the scheduling-mode encoding and the level
// decode used by the five-master arbiter.
// Assumes: level fields are PW bits wide and valid levels are 1..N_LVL.
package bus_arb5_pkg;

    localparam int unsigned ARB_MST = 5;
    localparam int unsigned ARB_LVL = 5;
    localparam int unsigned ARB_PW  = 3;
    localparam int unsigned ARB_DW  = 32;

    // Bit 0 of the configuration word selects the policy.
    typedef enum logic {
        SCHED_PRIO = 1'b0,
        SCHED_RR   = 1'b1
    } sched_e;

    // Maps a raw level field to its effective level; out-of-range values count as 1.
    function automatic logic [ARB_PW-1:0] eff_level(input logic [ARB_PW-1:0] fld);
        if (fld == '0 || int'(fld) > ARB_LVL) begin
            return ARB_PW'(1);
        end
        return fld;
    endfunction

endpackage

// File: rtl/arb5_cfg_reg.sv
// Module: configuration word storage.
// Stores the full word on a write strobe and returns it continuously.
// Assumes: synchronous active-low reset loads RST_VAL.
module arb5_cfg_reg #(
    parameter int unsigned DW      = 32,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    // Load the reset value or capture a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/arb5_prio_mask.sv
// Module: top-level selector for priority mode.
// Decodes each master's level field, finds the largest level among the
// requesters and returns the requesters at that level.
// Assumes: field of master m starts at bit 1 + PW*m of the configuration word.
module arb5_prio_mask
    import bus_arb5_pkg::*;
#(
    parameter int unsigned N_MST = ARB_MST,
    parameter int unsigned PW    = ARB_PW,
    parameter int unsigned DW    = ARB_DW
) (
    input  logic [DW-1:0]    cfg,
    input  logic [N_MST-1:0] req,
    output logic [N_MST-1:0] top_mask,
    output logic [PW-1:0]    top_lvl
);

    logic [PW-1:0] lvl [N_MST];

    // One level decoder per master.
    for (genvar m = 0; m < N_MST; m++) begin : g_lvl
        assign lvl[m] = eff_level(cfg[1 + PW*m +: PW]);
    end

    // Find the highest requesting level, then mark the requesters at that level.
    always_comb begin
        top_lvl  = '0;
        top_mask = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (req[m] && lvl[m] > top_lvl) begin
                top_lvl = lvl[m];
            end
        end
        for (int m = 0; m < N_MST; m++) begin
            top_mask[m] = req[m] && (lvl[m] == top_lvl);
        end
    end

endmodule

// File: rtl/arb5_rr_pick.sv
// Module: rotating first-one picker.
// Scans the candidate mask starting at ptr and wrapping around, and returns
// the first set bit as one-hot and as an index.
// Assumes: ptr < N.
module arb5_rr_pick #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    int unsigned pos;

    // Rotating scan from the pointer position.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        pos = 0;
        for (int k = 0; k < N; k++) begin
            pos = (int'(ptr) + k) % N;
            if (!any && mask[pos]) begin
                any      = 1'b1;
                idx      = IW'(pos);
                gnt[pos] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_arb5.sv
// Module: five-master shared bus arbiter (top).
// Holds the grant until xfer_done, and re-arbitrates at any edge where the
// bus is unowned or the owner finishes. Offers rotating or level-based
// policy, with one turn pointer for rotating mode and one per level.
// Assumes: xfer_done is only meaningful while a grant is held.
module bus_arb5
    import bus_arb5_pkg::*;
#(
    parameter int unsigned   N_MST   = ARB_MST,
    parameter int unsigned   N_LVL   = ARB_LVL,
    parameter int unsigned   PW      = ARB_PW,
    parameter int unsigned   DW      = ARB_DW,
    parameter logic [DW-1:0] RST_CFG = DW'(32'h0000_0145)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic             xfer_done,
    input  logic             cfg_we,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic [N_MST-1:0] grant
);

    localparam int unsigned IW   = $clog2(N_MST);
    localparam int unsigned NPTR = 1 << PW;

    logic [DW-1:0]    cfg_q;
    logic [N_MST-1:0] top_mask;
    logic [PW-1:0]    top_lvl;
    logic [N_MST-1:0] cand;
    logic [IW-1:0]    start_ptr;
    logic [N_MST-1:0] pick_gnt;
    logic [IW-1:0]    pick_idx;
    logic             pick_any;
    logic [IW-1:0]    next_ptr;
    logic             arb_pt;
    sched_e           mode;

    logic [IW-1:0]    rr_ptr;
    logic [IW-1:0]    lvl_ptr [NPTR];

    arb5_cfg_reg #(
        .DW      (DW),
        .RST_VAL (RST_CFG)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    arb5_prio_mask #(
        .N_MST (N_MST),
        .PW    (PW),
        .DW    (DW)
    ) prio_i (
        .cfg      (cfg_q),
        .req      (req),
        .top_mask (top_mask),
        .top_lvl  (top_lvl)
    );

    arb5_rr_pick #(
        .N  (N_MST),
        .IW (IW)
    ) pick_i (
        .mask (cand),
        .ptr  (start_ptr),
        .gnt  (pick_gnt),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    assign cfg_rdata = cfg_q;
    assign mode      = sched_e'(cfg_q[0]);
    assign arb_pt    = (grant == '0) || xfer_done;

    // Select the candidates and the start pointer for the active policy.
    always_comb begin
        if (mode == SCHED_RR) begin
            cand      = req;
            start_ptr = rr_ptr;
        end else begin
            cand      = top_mask;
            start_ptr = lvl_ptr[top_lvl];
        end
    end

    // Position after the winner, wrapping at the last master.
    assign next_ptr = (pick_idx == IW'(N_MST - 1)) ? '0 : pick_idx + 1'b1;

    // Grant register: updated only at arbitration points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else if (arb_pt) begin
            grant <= pick_gnt;
        end
    end

    // Turn pointers: move past the winner of the mode that chose it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
            for (int l = 0; l < NPTR; l++) begin
                lvl_ptr[l] <= '0;
            end
        end else if (arb_pt && pick_any) begin
            if (mode == SCHED_RR) begin
                rr_ptr <= next_ptr;
            end else begin
                lvl_ptr[top_lvl] <= next_ptr;
            end
        end
    end

endmodule

// File: rtl/bus_arb5_chk.sv
// Module: property checker for the arbiter, attached with bind.
// Assumes: observes the top-level ports only and keeps its own history
// registers for the priority check.
module bus_arb5_chk
    import bus_arb5_pkg::*;
#(
    parameter int unsigned N_MST = ARB_MST,
    parameter int unsigned PW    = ARB_PW,
    parameter int unsigned DW    = ARB_DW
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] req,
    input logic             xfer_done,
    input logic             cfg_we,
    input logic [DW-1:0]    cfg_wdata,
    input logic [DW-1:0]    cfg_rdata,
    input logic [N_MST-1:0] grant
);

    logic          pend_chk;
    logic [PW-1:0] pend_max;
    logic [DW-1:0] pend_cfg;
    logic [PW-1:0] req_max;
    logic [PW-1:0] gnt_lvl;

    // Largest level among the current requesters under the stored word.
    always_comb begin
        req_max = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (req[m] && eff_level(cfg_rdata[1 + PW*m +: PW]) > req_max) begin
                req_max = eff_level(cfg_rdata[1 + PW*m +: PW]);
            end
        end
    end

    // Level of the master now granted, under the word used for the decision.
    always_comb begin
        gnt_lvl = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (grant[m]) begin
                gnt_lvl = eff_level(pend_cfg[1 + PW*m +: PW]);
            end
        end
    end

    // Remember each priority-mode decision that had requesters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_chk <= 1'b0;
            pend_max <= '0;
            pend_cfg <= '0;
        end else begin
            pend_chk <= ((grant == '0) || xfer_done) && !cfg_rdata[0] && (req != '0);
            pend_max <= req_max;
            pend_cfg <= cfg_rdata;
        end
    end

    AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));  // R2
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R3
    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != $past(grant)) && (grant != '0)) |-> ((grant & $past(req)) != '0));  // R3
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (((grant == '0) || xfer_done) && (req == '0)) |=> (grant == '0));  // R4
    AST_HOLD_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !xfer_done) |=> $stable(grant));  // R5
    AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        pend_chk |-> ((grant != '0) && (gnt_lvl == pend_max)));  // R8

endmodule

bind bus_arb5 bus_arb5_chk #(
    .N_MST (N_MST),
    .PW    (PW),
    .DW    (DW)
) chk_i (.*);

// File: tb/bus_arb5_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, all
// compared each cycle with a reference model built from the requirements.
module bus_arb5_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  req = '0;
    logic        xfer_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [4:0]  grant;

    int n_chk = 0;
    int n_err = 0;
    bit fin = 0;

    // Reference state.
    logic [4:0]  m_grant;
    logic [31:0] m_cfg;
    int          m_rr;
    int          m_lp [8];
    int          waits [5];

    always #2 clk = ~clk;

    bus_arb5 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .xfer_done (xfer_done),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .grant     (grant)
    );

    function automatic int lvl_of(input logic [31:0] c, input int m);
        int f;
        f = int'((c >> (3*m + 1)) & 32'd7);
        return (f == 0 || f > 5) ? 1 : f;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, and compare after the edge.
    task automatic step(input logic [4:0] r, input logic d, input logic w,
                        input logic [31:0] wd, input string tag);
        logic [4:0]  mask;
        logic [31:0] old_cfg;
        int top, start, win, idx, maxw;
        bit pt;
        req = r; xfer_done = d; cfg_we = w; cfg_wdata = wd;
        old_cfg = m_cfg;
        pt = (m_grant == '0) || d;
        top = 0;
        if (pt) begin
            mask = r;
            if (!old_cfg[0]) begin
                for (int m = 0; m < 5; m++) if (r[m] && lvl_of(old_cfg, m) > top) top = lvl_of(old_cfg, m);
                mask = '0;
                for (int m = 0; m < 5; m++) if (r[m] && lvl_of(old_cfg, m) == top) mask[m] = 1'b1;
                start = m_lp[top];
            end else begin
                start = m_rr;
            end
            win = -1;
            for (int k = 0; k < 5; k++) begin
                idx = (start + k) % 5;
                if (win < 0 && mask[idx]) win = idx;
            end
            m_grant = (win < 0) ? 5'b0 : 5'(5'b1 << win);
            if (win >= 0) begin
                if (old_cfg[0]) m_rr = (win + 1) % 5;
                else m_lp[top] = (win + 1) % 5;
            end
        end
        if (w) m_cfg = wd;
        @(posedge clk);
        @(negedge clk);
        chk(grant == m_grant, tag, 32'(grant), 32'(m_grant));
        chk(cfg_rdata == m_cfg, "R2", cfg_rdata, m_cfg);
        // R8: granted level equals the highest requesting level.
        if (pt && !old_cfg[0] && r != '0) begin
            idx = 0;
            for (int m = 0; m < 5; m++) if (grant[m]) idx = m;
            chk((grant != '0) && lvl_of(old_cfg, idx) == top, "R8",
                32'(lvl_of(old_cfg, idx)), 32'(top));
        end
        // R7: a persistent requester waits fewer than 5 granting points.
        if (pt && old_cfg[0] && r != '0) begin
            maxw = 0;
            for (int m = 0; m < 5; m++) begin
                if (r[m] && !grant[m]) waits[m]++;
                else waits[m] = 0;
                if (waits[m] > maxw) maxw = waits[m];
            end
            chk(maxw < 5, "R7", 32'(maxw), 32'd4);
        end
    endtask

    initial begin
        logic [4:0] rr;
        logic [31:0] wd;
        void'($urandom(32'd4242));
        m_grant = '0; m_cfg = 32'h145; m_rr = 0;
        for (int l = 0; l < 8; l++) m_lp[l] = 0;
        for (int m = 0; m < 5; m++) waits[m] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant == '0, "R1", 32'(grant), 32'h0);
        chk(cfg_rdata == 32'h145, "R1", cfg_rdata, 32'h145);

        // No requests: no grant.
        repeat (3) step(5'b00000, 1'b0, 1'b0, '0, "R4");
        chk(grant == '0, "R4", 32'(grant), 32'h0);

        // Rotating order from master 0.
        step(5'b11111, 1'b0, 1'b0, '0, "R7");
        chk(grant == 5'b00001, "R7", 32'(grant), 32'h01);
        step(5'b11111, 1'b1, 1'b0, '0, "R7");
        chk(grant == 5'b00010, "R7", 32'(grant), 32'h02);
        step(5'b11111, 1'b1, 1'b0, '0, "R6");
        chk(grant == 5'b00100, "R6", 32'(grant), 32'h04);
        step(5'b11111, 1'b1, 1'b0, '0, "R7");
        step(5'b11111, 1'b1, 1'b0, '0, "R7");
        chk(grant == 5'b10000, "R7", 32'(grant), 32'h10);
        step(5'b11111, 1'b1, 1'b0, '0, "R7");
        chk(grant == 5'b00001, "R7", 32'(grant), 32'h01);

        // Hold during transfer while a priority word is written.
        step(5'b11110, 1'b0, 1'b1, 32'h0000_15D2, "R5");
        step(5'b11110, 1'b0, 1'b0, '0, "R11");
        step(5'b00110, 1'b0, 1'b0, '0, "R5");
        chk(grant == 5'b00001, "R5", 32'(grant), 32'h01);
        chk(cfg_rdata == 32'h15D2, "R2", cfg_rdata, 32'h15D2);

        // Priority mode: levels 1,5,3,5,0(->1).
        step(5'b11111, 1'b1, 1'b0, '0, "R11");
        chk(grant == 5'b00010, "R11", 32'(grant), 32'h02);
        step(5'b11111, 1'b1, 1'b0, '0, "R10");
        chk(grant == 5'b01000, "R10", 32'(grant), 32'h08);
        step(5'b11111, 1'b1, 1'b0, '0, "R10");
        chk(grant == 5'b00010, "R10", 32'(grant), 32'h02);
        step(5'b00101, 1'b1, 1'b0, '0, "R8");
        chk(grant == 5'b00100, "R8", 32'(grant), 32'h04);
        step(5'b10001, 1'b1, 1'b0, '0, "R9");
        chk(grant == 5'b00001, "R9", 32'(grant), 32'h01);
        step(5'b10001, 1'b1, 1'b0, '0, "R9");
        chk(grant == 5'b10000, "R9", 32'(grant), 32'h10);
        step(5'b00000, 1'b1, 1'b0, '0, "R4");
        chk(grant == '0, "R4", 32'(grant), 32'h0);

        // Back to rotating mode, then random traffic.
        step(5'b00000, 1'b0, 1'b1, 32'h0000_0145, "R2");
        rr = 5'b11111;
        for (int i = 0; i < 4000; i++) begin
            for (int m = 0; m < 5; m++) if ($urandom % 4 == 0) rr[m] = ~rr[m];
            wd = $urandom;
            if ($urandom % 3 == 0) wd[0] = 1'b1;
            step(rr, ($urandom % 3) == 0, ($urandom % 40) == 0, wd, "R3");
            chk($onehot0(grant), "R3", 32'(grant), 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        fin = 1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule